// File: doc/BRIEF.md
# Stub Level-2 Cache Control Registers

This block presents the software-visible control face of a level-2 cache controller on a 32-bit APB-style peripheral bus. No cache storage or data path sits behind it. Firmware can program control, auxiliary, latency and address-filter words and read them back. It reads a fixed identification word and a cache-type word that reflects the auxiliary settings. Any maintenance operation it issues is reported complete at once. Accesses to undefined offsets never stall the bus and never raise an error response. They only pulse a debug strobe.

Only the low 12 bits of the address are decoded, so the 4 KB window repeats across any larger aperture. Every access finishes in its first access-phase cycle.

Top module: `l2stub_regs`

## Requirements
- R1: After reset, control reads 0, auxiliary reads 0x02020000, and both latency words and both filter words read 0.
- R2: A read at offset 0x000 returns 0x410000C8. A write there changes nothing and counts as a bad access.
- R3: A write to offset 0x100 keeps only bit 0, and reads of 0x100 return zero in bits 31:1.
- R4: Offsets 0x104 (auxiliary), 0x108 (tag latency), 0x10C (data latency), 0xC00 (filter start) and 0xC04 (filter end) store and return all 32 written bits.
- R5: A read at 0x004 returns the stored type word OR'd with a 4-bit value v placed at bits 21:18 and again at bits 9:6. Here v[3:1] = auxiliary[19:17] and v[0] = auxiliary[16]. The stored type word loads from a parameter at reset, with default 0x1C100100. A write to 0x004 changes nothing and counts as a bad access.
- R6: Each read at 0x004 writes its result back into the stored type word. Bits set this way stay set after the auxiliary register is cleared.
- R7: Any offset from 0x730 through 0x7FF reads zero, drops writes, and is not a bad access.
- R8: Offsets 0xF40, 0xF60 and 0xF80 read zero, drop writes, and are not bad accesses.
- R9: Any other offset reads zero and drops writes. In that case bad_access is high for exactly the one cycle after the access phase.
- R10: Address bits above bit 11 are ignored, so a register can be reached through any alias of the window.
- R11: pready is high during every access phase, and prdata is valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access-phase qualifier |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address, only bits 11:0 decoded |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pready | output | 1 | Transfer complete |
| bad_access | output | 1 | One-cycle strobe after an access to an undefined offset |

## Verification
The hardest state to reach is the sticky type word. Bits remembered from earlier auxiliary settings can only be observed by reading the type word once under one auxiliary value, reprogramming the auxiliary register, and reading again. The bench does this with a non-default value, then clears the auxiliary register and reads again. This shows that the earlier fields survive and that no new ones appear. Dropped writes are shown by writing to quiet, maintenance and undefined offsets, then reading back every stored register through the bus.

// File: rtl/l2stub_pkg.sv
package l2stub_pkg;
  localparam int DATA_W = 32;
  localparam int OFF_W  = 12;

  typedef enum logic [3:0] {
    K_ID, K_TYPE, K_CTRL, K_AUX, K_TAG, K_DATA, K_FST, K_FEND, K_QUIET, K_BAD
  } reg_kind_e;

  localparam logic [OFF_W-1:0] OFF_ID    = 12'h000;
  localparam logic [OFF_W-1:0] OFF_TYPE  = 12'h004;
  localparam logic [OFF_W-1:0] OFF_CTRL  = 12'h100;
  localparam logic [OFF_W-1:0] OFF_AUX   = 12'h104;
  localparam logic [OFF_W-1:0] OFF_TAG   = 12'h108;
  localparam logic [OFF_W-1:0] OFF_DATA  = 12'h10C;
  localparam logic [OFF_W-1:0] OFF_FST   = 12'hC00;
  localparam logic [OFF_W-1:0] OFF_FEND  = 12'hC04;
  localparam logic [OFF_W-1:0] OFF_CMO_LO = 12'h730;
  localparam logic [OFF_W-1:0] OFF_CMO_HI = 12'h800;
  localparam logic [OFF_W-1:0] OFF_Q0    = 12'hF40;
  localparam logic [OFF_W-1:0] OFF_Q1    = 12'hF60;
  localparam logic [OFF_W-1:0] OFF_Q2    = 12'hF80;

  localparam logic [DATA_W-1:0] AUX_RESET = 32'h0202_0000;
endpackage

// File: rtl/l2stub_decode.sv
module l2stub_decode
  import l2stub_pkg::*;
(
  input  logic [OFF_W-1:0] offset,
  input  logic             wr,
  output reg_kind_e        kind
);
  always_comb begin
    kind = K_BAD;
    if (offset >= OFF_CMO_LO && offset < OFF_CMO_HI) begin
      kind = K_QUIET;
    end else begin
      case (offset)
        OFF_ID:   kind = wr ? K_BAD : K_ID;
        OFF_TYPE: kind = wr ? K_BAD : K_TYPE;
        OFF_CTRL: kind = K_CTRL;
        OFF_AUX:  kind = K_AUX;
        OFF_TAG:  kind = K_TAG;
        OFF_DATA: kind = K_DATA;
        OFF_FST:  kind = K_FST;
        OFF_FEND: kind = K_FEND;
        OFF_Q0, OFF_Q1, OFF_Q2: kind = K_QUIET;
        default:  kind = K_BAD;
      endcase
    end
  end
endmodule

// File: rtl/l2stub_regfile.sv
module l2stub_regfile
  import l2stub_pkg::*;
#(
  parameter logic [DATA_W-1:0] TYPE_RESET = 32'h1C10_0100,
  parameter logic [DATA_W-1:0] ID_WORD    = 32'h4100_00C8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              wr,
  input  reg_kind_e         kind,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int FOLD_HI = 18;
  localparam int FOLD_LO = 6;

  logic              ctrl_q, ctrl_d;
  logic [DATA_W-1:0] aux_q, aux_d, tag_q, tag_d, dat_q, dat_d;
  logic [DATA_W-1:0] fst_q, fst_d, fend_q, fend_d, type_q, type_d;
  logic [3:0]        fold_v;
  logic [DATA_W-1:0] type_rd;
  logic              wr_en, rd_en;

  assign wr_en  = acc_en && wr;
  assign rd_en  = acc_en && !wr;
  assign fold_v = {aux_q[19:17], aux_q[16]};
  assign type_rd = type_q | (DATA_W'(fold_v) << FOLD_HI) | (DATA_W'(fold_v) << FOLD_LO);

  always_comb begin
    ctrl_d = ctrl_q;
    aux_d  = aux_q;
    tag_d  = tag_q;
    dat_d  = dat_q;
    fst_d  = fst_q;
    fend_d = fend_q;
    type_d = type_q;
    if (wr_en) begin
      case (kind)
        K_CTRL:  ctrl_d = wdata[0];
        K_AUX:   aux_d  = wdata;
        K_TAG:   tag_d  = wdata;
        K_DATA:  dat_d  = wdata;
        K_FST:   fst_d  = wdata;
        K_FEND:  fend_d = wdata;
        default: ;
      endcase
    end
    if (rd_en && kind == K_TYPE) type_d = type_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= 1'b0;
      aux_q  <= AUX_RESET;
      tag_q  <= '0;
      dat_q  <= '0;
      fst_q  <= '0;
      fend_q <= '0;
      type_q <= TYPE_RESET;
    end else begin
      ctrl_q <= ctrl_d;
      aux_q  <= aux_d;
      tag_q  <= tag_d;
      dat_q  <= dat_d;
      fst_q  <= fst_d;
      fend_q <= fend_d;
      type_q <= type_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (kind)
        K_ID:    rdata = ID_WORD;
        K_TYPE:  rdata = type_rd;
        K_CTRL:  rdata = {{(DATA_W-1){1'b0}}, ctrl_q};
        K_AUX:   rdata = aux_q;
        K_TAG:   rdata = tag_q;
        K_DATA:  rdata = dat_q;
        K_FST:   rdata = fst_q;
        K_FEND:  rdata = fend_q;
        default: rdata = '0;
      endcase
    end
  end

  // R6: the stored type word never loses a bit once set
  p_type_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((type_q & $past(type_q)) == $past(type_q)));

  // R4: auxiliary register changes only on a write aimed at it
  p_aux_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(aux_q) |-> $past(wr_en && kind == K_AUX));
endmodule

// File: rtl/l2stub_regs.sv
module l2stub_regs
  import l2stub_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter logic [DATA_W-1:0] TYPE_RESET = 32'h1C10_0100,
  parameter logic [DATA_W-1:0] ID_WORD    = 32'h4100_00C8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              bad_access
);
  logic             acc_en;
  logic [OFF_W-1:0] offset;
  reg_kind_e        kind;
  logic             bad_d, bad_q;

  assign acc_en = psel && penable;
  assign offset = paddr[OFF_W-1:0];
  assign pready = psel;

  generate
    if (ADDR_W > OFF_W) begin : g_alias
      logic unused_hi;
      assign unused_hi = ^paddr[ADDR_W-1:OFF_W];
    end
  endgenerate

  l2stub_decode u_decode (
    .offset (offset),
    .wr     (pwrite),
    .kind   (kind)
  );

  l2stub_regfile #(
    .TYPE_RESET (TYPE_RESET),
    .ID_WORD    (ID_WORD)
  ) u_regfile (
    .clk    (clk),
    .rst_n  (rst_n),
    .acc_en (acc_en),
    .wr     (pwrite),
    .kind   (kind),
    .wdata  (pwdata),
    .rdata  (prdata)
  );

  assign bad_d = acc_en && (kind == K_BAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bad_q <= 1'b0;
    else        bad_q <= bad_d;
  end
  assign bad_access = bad_q;

  // R11: ready is up for every access phase
  p_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_en |-> pready);

  // R9: strobe follows an access phase and lasts one cycle
  p_bad_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |-> $past(acc_en));
  p_bad_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |=> !bad_access);

  // R2: identification read
  p_id_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !pwrite && offset == OFF_ID) |-> prdata == ID_WORD);

  // R7: maintenance window reads zero and is never flagged
  p_cmo_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && offset >= OFF_CMO_LO && offset < OFF_CMO_HI)
      |-> (prdata == '0) ##1 !bad_access);

  // R3: control readback has only bit 0
  p_ctrl_bit0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !pwrite && offset == OFF_CTRL) |-> prdata[DATA_W-1:1] == '0);
endmodule

// File: tb/l2stub_regs_tb.sv
module l2stub_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        psel, penable, pwrite;
  logic [31:0] paddr, pwdata, prdata;
  logic        pready, bad_access;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  l2stub_regs u_dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .bad_access(bad_access)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // one transfer; returns read data, ready, and the strobe in the two following cycles
  task automatic xfer(input logic wr, input logic [31:0] a, input logic [31:0] d,
                      output logic [31:0] rd, output logic rdy, output logic b1, output logic b2);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1;
    #1;
    rd = prdata; rdy = pready;
    @(negedge clk);
    b1 = bad_access;
    psel = 0; penable = 0; pwrite = 0;
    @(negedge clk);
    b2 = bad_access;
  endtask

  task automatic wr32(input string req, input logic [31:0] a, input logic [31:0] d, input logic exp_bad);
    logic [31:0] rd; logic rdy, b1, b2;
    xfer(1'b1, a, d, rd, rdy, b1, b2);
    check({req, " ready"}, {31'b0, rdy}, 32'd1);
    check({req, " strobe"}, {30'b0, b1, b2}, {30'b0, exp_bad, 1'b0});
  endtask

  task automatic rd32(input string req, input logic [31:0] a, input logic [31:0] exp, input logic exp_bad);
    logic [31:0] rd; logic rdy, b1, b2;
    xfer(1'b0, a, 32'h0, rd, rdy, b1, b2);
    check(req, rd, exp);
    check({req, " ready"}, {31'b0, rdy}, 32'd1);
    check({req, " strobe"}, {30'b0, b1, b2}, {30'b0, exp_bad, 1'b0});
  endtask

  task automatic t_reset;
    rd32("R1 ctrl", 32'h100, 32'h0, 0);
    rd32("R1 aux", 32'h104, 32'h0202_0000, 0);
    rd32("R1 tag", 32'h108, 32'h0, 0);
    rd32("R1 data", 32'h10C, 32'h0, 0);
    rd32("R1 fst", 32'hC00, 32'h0, 0);
    rd32("R1 fend", 32'hC04, 32'h0, 0);
  endtask

  task automatic t_id;
    rd32("R2 id", 32'h000, 32'h4100_00C8, 0);
    wr32("R2 id write", 32'h000, 32'hFFFF_FFFF, 1);
    rd32("R2 id after write", 32'h000, 32'h4100_00C8, 0);
  endtask

  task automatic t_ctrl;
    wr32("R3 ctrl", 32'h100, 32'hFFFF_FFFF, 0);
    rd32("R3 ctrl one", 32'h100, 32'h1, 0);
    wr32("R3 ctrl", 32'h100, 32'hFFFF_FFFE, 0);
    rd32("R3 ctrl zero", 32'h100, 32'h0, 0);
  endtask

  task automatic t_rw;
    wr32("R4 tag", 32'h108, 32'hA5A5_1234, 0);
    wr32("R4 data", 32'h10C, 32'h5A5A_8765, 0);
    wr32("R4 fst", 32'hC00, 32'hDEAD_BEEF, 0);
    wr32("R4 fend", 32'hC04, 32'hCAFE_F00D, 0);
    rd32("R4 tag", 32'h108, 32'hA5A5_1234, 0);
    rd32("R4 data", 32'h10C, 32'h5A5A_8765, 0);
    rd32("R4 fst", 32'hC00, 32'hDEAD_BEEF, 0);
    rd32("R4 fend", 32'hC04, 32'hCAFE_F00D, 0);
  endtask

  task automatic t_type;
    // default aux 0x02020000 gives v=2 -> OR 0x00080080
    rd32("R5 type default", 32'h004, 32'h1C18_0180, 0);
    wr32("R5 type write", 32'h004, 32'h0, 1);
    wr32("R4 aux", 32'h104, 32'h000F_0000, 0);
    rd32("R4 aux", 32'h104, 32'h000F_0000, 0);
    rd32("R5 type v15", 32'h004, 32'h1C3C_03C0, 0);
    wr32("R6 aux clear", 32'h104, 32'h0, 0);
    rd32("R6 type sticky", 32'h004, 32'h1C3C_03C0, 0);
  endtask

  task automatic t_quiet;
    wr32("R7 cmo low", 32'h730, 32'hFFFF_FFFF, 0);
    wr32("R7 cmo high", 32'h7FC, 32'hFFFF_FFFF, 0);
    rd32("R7 cmo read", 32'h770, 32'h0, 0);
    rd32("R7 cmo top", 32'h7FC, 32'h0, 0);
    wr32("R8 quiet f40", 32'hF40, 32'h1, 0);
    wr32("R8 quiet f60", 32'hF60, 32'h1, 0);
    rd32("R8 quiet f80", 32'hF80, 32'h0, 0);
    rd32("R9 below cmo", 32'h72C, 32'h0, 1);
    rd32("R9 at 800", 32'h800, 32'h0, 1);
    wr32("R9 bad write", 32'h110, 32'hFFFF_FFFF, 1);
    rd32("R9 bad read", 32'h110, 32'h0, 1);
    rd32("R7 regs intact ctrl", 32'h100, 32'h0, 0);
    rd32("R8 regs intact aux", 32'h104, 32'h0, 0);
    rd32("R9 regs intact tag", 32'h108, 32'hA5A5_1234, 0);
    rd32("R9 regs intact fend", 32'hC04, 32'hCAFE_F00D, 0);
  endtask

  task automatic t_alias;
    wr32("R10 alias aux", 32'h1234_5104, 32'h1357_9BDF, 0);
    rd32("R10 alias read", 32'h104, 32'h1357_9BDF, 0);
    rd32("R10 alias id", 32'hFFFF_F000, 32'h4100_00C8, 0);
  endtask

  initial begin
    rst_n = 0; psel = 0; penable = 0; pwrite = 0; paddr = 0; pwdata = 0;
    repeat (3) @(negedge clk);
    check("R1 strobe in reset", {31'b0, bad_access}, 32'h0);
    rst_n = 1;
    t_reset();
    t_id();
    t_ctrl();
    t_rw();
    t_type();
    t_quiet();
    t_alias();
    check("R11 idle strobe", {31'b0, bad_access}, 32'h0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog actual=%08h expected=%08h", 0, 1);
        end
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule